// File: doc/BRIEF.md
# Binary-Search Histogramming Time-to-Digital Controller

This controller finds the arrival bin of a reflected laser pulse by successive approximation. It does not keep a full histogram of every time bin. One clock period of the reference clock is one time bin. Each laser-fire strobe opens a frame of 64 bins. Synchronised single-photon detector pulses that land in selected bins steer one shared signed event counter up or down.

For each code bit, from the most significant bit down, the current candidate interval is split into an earlier half and a later half. Hits in the earlier half add to the counter and hits in the later half subtract from it. After a programmable number of frames, the sign of the counter picks the half that is kept.

Once the six coarse bits are known, the same counter becomes an up-only counter. It collects hits in the found bin during one phase and in the bin that follows during a second phase. The counter is the only histogram storage the block holds. The two counts are handed out so that later logic can form their ratio and place the return inside the coarse bin. One coarse bin stands for 150 cm of range; the fine interpolation targets 9 cm steps.

Top module: `sa_tdc_ctrl`

## Requirements
- R1: A pulse on `start_i` while idle begins a search and raises `busy_o`. `busy_o` stays high until the search ends. A `start_i` pulse while busy has no effect on the result.
- R2: While busy and no frame is open, a `fire_i` pulse opens a frame of 64 bins. Bin 0 is the clock cycle after the one in which `fire_i` is sampled, and each later cycle is the next bin. A `fire_i` pulse during an open frame is ignored, and `det_i` outside an open frame is not counted.
- R3: Code bits are resolved from bit 5 down to bit 0. For bit b, the candidate interval starts at the bits already found (`coarse_code_o`) and spans 2^(b+1) bins. Hits in the lower 2^b bins count +1 and hits in the upper 2^b bins count −1. A final count of zero or more sets bit b to 0. A negative count sets bit b to 1, which moves the interval start up by 2^b.
- R4: During the coarse search the counter is a 10-bit two's-complement value that saturates at +511 and −512 instead of wrapping. It is cleared at the start of every search step.
- R5: Each search step and each fine phase lasts N frames. N is `cfg_frames_i` sampled at start, and a value of 0 is treated as 1.
- R6: After the coarse search, two fine phases of N frames each count hits up only, saturating at 1023. The first phase counts bin k and its result appears on `fine_a_o`. The second phase counts bin k+1 and its result appears on `fine_b_o`.
- R7: k equals the final coarse code, except that a code of 63 gives k = 62 so both fine bins lie inside the range. `fine_bin_o` shows k.
- R8: `done_o` is a one-cycle pulse in the cycle in which `busy_o` falls. The code and the fine counts then hold until the next start, which clears the fine counts to 0.
- R9: After reset, `busy_o` and `done_o` are 0, and `coarse_code_o`, `fine_bin_o`, `fine_a_o` and `fine_b_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock; one period is one time bin |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a search |
| cfg_frames_i | input | 8 | Frames per search step and per fine phase |
| fire_i | input | 1 | Laser-fire strobe |
| det_i | input | 1 | Synchronised detector pulse |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| coarse_code_o | output | 6 | Coarse bin code (partial during the search) |
| fine_bin_o | output | 6 | First of the two fine bins |
| fine_a_o | output | 10 | Hit count in bin k |
| fine_b_o | output | 10 | Hit count in bin k+1 |

## Verification
The hardest state to reach from the ports is counter saturation. One hit per frame would need hundreds of frames in a single step before the counter reaches its limit. The stimulus instead holds the detector high across the whole first half of each frame, so that 20 frames push 640 hits into the most significant step. A counter that wrapped would turn negative and set the top code bit. Other searches cover a tie between two adjacent bins, a return in the last bin with the neighbour clamp, and a zero frame setting. These searches also inject strobes, detector pulses and start pulses that must be ignored. A behavioural model checks every output on every cycle.

// File: rtl/sa_tdc_pkg.sv
package sa_tdc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_COARSE = 2'd1,
    ST_FINE_A = 2'd2,
    ST_FINE_B = 2'd3
  } seq_state_e;
endpackage

// File: rtl/sa_tdc_rst_sync.sv
module sa_tdc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/sa_tdc_frame.sv
module sa_tdc_frame #(
  parameter int TB_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            fire_i,
  output logic [TB_W-1:0] bin_o,
  output logic            bin_vld_o,
  output logic            frame_end_o
);
  localparam logic [TB_W-1:0] LAST_BIN = '1;

  logic            act_q, act_d;
  logic [TB_W-1:0] bin_q, bin_d;
  logic            end_q, end_d;

  always_comb begin
    act_d = act_q;
    bin_d = bin_q;
    end_d = act_q && (bin_q == LAST_BIN);
    if (act_q) begin
      if (bin_q == LAST_BIN) act_d = 1'b0;
      else                   bin_d = bin_q + 1'b1;
    end else if (fire_i && en_i) begin
      act_d = 1'b1;
      bin_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      bin_q <= '0;
      end_q <= 1'b0;
    end else begin
      act_q <= act_d;
      bin_q <= bin_d;
      end_q <= end_d;
    end
  end

  assign bin_o       = bin_q;
  assign bin_vld_o   = act_q;
  assign frame_end_o = end_q;

  p_frame_open_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_q && fire_i && en_i) |=> (act_q && bin_q == '0));
  p_frame_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && bin_q == LAST_BIN) |=> (!act_q && end_q));
endmodule

// File: rtl/sa_tdc_gate.sv
module sa_tdc_gate
  import sa_tdc_pkg::*;
#(
  parameter int TB_W  = 6,
  parameter int BIT_W = 3
) (
  input  seq_state_e       st_i,
  input  logic [TB_W-1:0]  lo_i,
  input  logic [BIT_W-1:0] bit_i,
  input  logic [TB_W-1:0]  fbin_i,
  input  logic [TB_W-1:0]  bin_i,
  input  logic             bin_vld_i,
  input  logic             det_i,
  output logic             inc_o,
  output logic             dec_o
);
  localparam int EXT = TB_W + 1;

  logic [EXT-1:0] half_x, lo_x, mid_x, top_x, bin_x;
  logic           hit;

  always_comb begin
    half_x = EXT'(1) << bit_i;
    lo_x   = {1'b0, lo_i};
    mid_x  = lo_x + half_x;
    top_x  = mid_x + half_x;
    bin_x  = {1'b0, bin_i};
    hit    = bin_vld_i && det_i;
    inc_o  = 1'b0;
    dec_o  = 1'b0;
    case (st_i)
      ST_COARSE: begin
        inc_o = hit && (bin_x >= lo_x) && (bin_x < mid_x);
        dec_o = hit && (bin_x >= mid_x) && (bin_x < top_x);
      end
      ST_FINE_A: inc_o = hit && (bin_i == fbin_i);
      ST_FINE_B: inc_o = hit && (bin_i == fbin_i + TB_W'(1));
      default: begin
        inc_o = 1'b0;
        dec_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/sa_tdc_counter.sv
module sa_tdc_counter #(
  parameter int HB_W = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            up_only_i,
  input  logic            inc_i,
  input  logic            dec_i,
  output logic [HB_W-1:0] cnt_o
);
  localparam logic [HB_W-1:0] POS_MAX = {1'b0, {(HB_W-1){1'b1}}};
  localparam logic [HB_W-1:0] NEG_MIN = {1'b1, {(HB_W-1){1'b0}}};
  localparam logic [HB_W-1:0] U_MAX   = '1;

  logic [HB_W-1:0] cnt_q, cnt_d;
  logic            at_top;

  always_comb begin
    at_top = up_only_i ? (cnt_q == U_MAX) : (cnt_q == POS_MAX);
    cnt_d  = cnt_q;
    if (clr_i)                                        cnt_d = '0;
    else if (inc_i && !at_top)                        cnt_d = cnt_q + 1'b1;
    else if (dec_i && !up_only_i && cnt_q != NEG_MIN) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  p_clear_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
  p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !up_only_i && inc_i && cnt_q == POS_MAX) |=> (cnt_q == POS_MAX));
  p_no_underflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !up_only_i && dec_i && cnt_q == NEG_MIN) |=> (cnt_q == NEG_MIN));
  p_fine_sat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && up_only_i && inc_i && cnt_q == U_MAX) |=> (cnt_q == U_MAX));
endmodule

// File: rtl/sa_tdc_ctrl.sv
module sa_tdc_ctrl
  import sa_tdc_pkg::*;
#(
  parameter int TB_W  = 6,
  parameter int HB_W  = 10,
  parameter int CYC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CYC_W-1:0] cfg_frames_i,
  input  logic             fire_i,
  input  logic             det_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [TB_W-1:0]  coarse_code_o,
  output logic [TB_W-1:0]  fine_bin_o,
  output logic [HB_W-1:0]  fine_a_o,
  output logic [HB_W-1:0]  fine_b_o
);
  localparam int BIT_W = (TB_W > 1) ? $clog2(TB_W) : 1;
  localparam logic [BIT_W-1:0] TOP_BIT  = BIT_W'(TB_W - 1);
  localparam logic [TB_W-1:0]  LAST_BIN = '1;

  logic rst_n;

  seq_state_e       st_q, st_d;
  logic [TB_W-1:0]  lo_q, lo_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [CYC_W-1:0] frm_q, frm_d;
  logic [CYC_W-1:0] cfg_q, cfg_d;
  logic [HB_W-1:0]  fa_q, fa_d, fb_q, fb_d;
  logic             done_q, done_d;

  logic             clr, up_only, inc, dec, last_frm, busy;
  logic [TB_W-1:0]  bin, fbin, half;
  logic             bin_vld, frame_end;
  logic [HB_W-1:0]  cnt;

  sa_tdc_rst_sync #(.STAGES(2)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_no(rst_n)
  );

  sa_tdc_frame #(.TB_W(TB_W)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_n), .en_i(busy), .fire_i(fire_i),
    .bin_o(bin), .bin_vld_o(bin_vld), .frame_end_o(frame_end)
  );

  sa_tdc_gate #(.TB_W(TB_W), .BIT_W(BIT_W)) u_gate (
    .st_i(st_q), .lo_i(lo_q), .bit_i(bit_q), .fbin_i(fbin), .bin_i(bin),
    .bin_vld_i(bin_vld), .det_i(det_i), .inc_o(inc), .dec_o(dec)
  );

  sa_tdc_counter #(.HB_W(HB_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_n), .clr_i(clr), .up_only_i(up_only),
    .inc_i(inc), .dec_i(dec), .cnt_o(cnt)
  );

  assign busy     = (st_q != ST_IDLE);
  assign up_only  = (st_q == ST_FINE_A) || (st_q == ST_FINE_B);
  assign fbin     = (lo_q == LAST_BIN) ? (lo_q - TB_W'(1)) : lo_q;
  assign half     = TB_W'(1) << bit_q;
  assign last_frm = ({1'b0, frm_q} + (CYC_W+1)'(1)) >= {1'b0, cfg_q};

  always_comb begin
    st_d   = st_q;
    lo_d   = lo_q;
    bit_d  = bit_q;
    frm_d  = frm_q;
    cfg_d  = cfg_q;
    fa_d   = fa_q;
    fb_d   = fb_q;
    done_d = 1'b0;
    clr    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d  = ST_COARSE;
          lo_d  = '0;
          bit_d = TOP_BIT;
          frm_d = '0;
          cfg_d = cfg_frames_i;
          fa_d  = '0;
          fb_d  = '0;
          clr   = 1'b1;
        end
      end
      ST_COARSE: begin
        if (frame_end) begin
          if (last_frm) begin
            clr   = 1'b1;
            frm_d = '0;
            if (cnt[HB_W-1]) lo_d = lo_q + half;
            if (bit_q == '0) st_d  = ST_FINE_A;
            else             bit_d = bit_q - 1'b1;
          end else begin
            frm_d = frm_q + 1'b1;
          end
        end
      end
      ST_FINE_A: begin
        if (frame_end) begin
          if (last_frm) begin
            fa_d  = cnt;
            clr   = 1'b1;
            frm_d = '0;
            st_d  = ST_FINE_B;
          end else begin
            frm_d = frm_q + 1'b1;
          end
        end
      end
      default: begin
        if (frame_end) begin
          if (last_frm) begin
            fb_d   = cnt;
            clr    = 1'b1;
            frm_d  = '0;
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            frm_d = frm_q + 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      lo_q   <= '0;
      bit_q  <= '0;
      frm_q  <= '0;
      cfg_q  <= '0;
      fa_q   <= '0;
      fb_q   <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      lo_q   <= lo_d;
      bit_q  <= bit_d;
      frm_q  <= frm_d;
      cfg_q  <= cfg_d;
      fa_q   <= fa_d;
      fb_q   <= fb_d;
      done_q <= done_d;
    end
  end

  assign busy_o        = busy;
  assign done_o        = done_q;
  assign coarse_code_o = lo_q;
  assign fine_bin_o    = fbin;
  assign fine_a_o      = fa_q;
  assign fine_b_o      = fb_q;

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_q |=> !done_q);
  p_busy_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(busy) |-> done_q);
  p_code_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    up_only |=> $stable(lo_q));
  p_count_in_frame_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (inc || dec) |-> bin_vld);
endmodule

// File: tb/tb_sa_tdc_ctrl.sv
`timescale 1ns/1ps
module tb_sa_tdc_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] cfg = 8'd0;
  logic       fire = 1'b0;
  logic       det = 1'b0;
  logic       busy, done;
  logic [5:0] code, fbin;
  logic [9:0] fa, fb;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit cmp_en = 0;
  int done_seen = 0;

  always #2 clk = ~clk;

  sa_tdc_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cfg_frames_i(cfg),
    .fire_i(fire), .det_i(det), .busy_o(busy), .done_o(done),
    .coarse_code_o(code), .fine_bin_o(fbin), .fine_a_o(fa), .fine_b_o(fb)
  );

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  int m_st, m_act, m_bin, m_end, m_cnt, m_lo, m_bit, m_frm, m_cfg, m_fa, m_fb, m_done;

  always @(posedge clk) begin
    int n_st, n_act, n_bin, n_end, n_cnt, n_lo, n_bit, n_frm, n_cfg, n_fa, n_fb, n_done;
    int k, h;
    bit hit, inc, dec, clr, last;
    cyc++;
    if (!rst_n) begin
      m_st = 0; m_act = 0; m_bin = 0; m_end = 0; m_cnt = 0; m_lo = 0;
      m_bit = 0; m_frm = 0; m_cfg = 0; m_fa = 0; m_fb = 0; m_done = 0;
    end else begin
      n_st = m_st; n_act = m_act; n_bin = m_bin; n_cnt = m_cnt; n_lo = m_lo;
      n_bit = m_bit; n_frm = m_frm; n_cfg = m_cfg; n_fa = m_fa; n_fb = m_fb; n_done = 0;
      hit = m_act && det;
      inc = 0; dec = 0; clr = 0;
      k = (m_lo == 63) ? 62 : m_lo;
      h = 1 << m_bit;
      if (m_st == 1) begin
        if (hit && m_bin >= m_lo && m_bin < m_lo + h) inc = 1;
        else if (hit && m_bin >= m_lo + h && m_bin < m_lo + 2*h) dec = 1;
      end else if (m_st == 2) inc = hit && (m_bin == k);
      else if (m_st == 3) inc = hit && (m_bin == k + 1);
      n_end = m_act && (m_bin == 63);
      if (m_act) begin
        if (m_bin == 63) n_act = 0; else n_bin = m_bin + 1;
      end else if (fire && m_st != 0) begin
        n_act = 1; n_bin = 0;
      end
      last = (m_frm + 1) >= m_cfg;
      case (m_st)
        0: if (start) begin
             n_st = 1; n_lo = 0; n_bit = 5; n_frm = 0; n_cfg = cfg;
             n_fa = 0; n_fb = 0; clr = 1;
           end
        1: if (m_end) begin
             if (last) begin
               clr = 1; n_frm = 0;
               if (m_cnt < 0) n_lo = m_lo + h;
               if (m_bit == 0) n_st = 2; else n_bit = m_bit - 1;
             end else n_frm = m_frm + 1;
           end
        2: if (m_end) begin
             if (last) begin n_fa = m_cnt; clr = 1; n_frm = 0; n_st = 3; end
             else n_frm = m_frm + 1;
           end
        default: if (m_end) begin
             if (last) begin n_fb = m_cnt; clr = 1; n_frm = 0; n_done = 1; n_st = 0; end
             else n_frm = m_frm + 1;
           end
      endcase
      if (clr) n_cnt = 0;
      else if (inc) begin
        if (m_cnt < ((m_st >= 2) ? 1023 : 511)) n_cnt = m_cnt + 1;
      end else if (dec && m_st == 1 && m_cnt > -512) n_cnt = m_cnt - 1;
      m_st = n_st; m_act = n_act; m_bin = n_bin; m_end = n_end; m_cnt = n_cnt;
      m_lo = n_lo; m_bit = n_bit; m_frm = n_frm; m_cfg = n_cfg; m_fa = n_fa;
      m_fb = n_fb; m_done = n_done;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_en) begin
      check_eq("R1 R5 busy", int'(busy), int'(m_st != 0));
      check_eq("R8 done", int'(done), m_done);
      check_eq("R3 coarse_code", int'(code), m_lo);
      check_eq("R7 fine_bin", int'(fbin), (m_lo == 63) ? 62 : m_lo);
      check_eq("R6 fine_a", int'(fa), m_fa);
      check_eq("R6 fine_b", int'(fb), m_fb);
    end
    if (done) done_seen++;
  end

  // knobs for ignored-stimulus injection
  bit g_fire_mid = 0;
  bit g_start_mid = 0;

  task automatic run_frame(input int a, input int b);
    @(negedge clk); fire = 1; det = 0;
    @(negedge clk); fire = 0;
    for (int i = 0; i < 64; i++) begin
      det   = (i >= a) && (i <= b);
      fire  = g_fire_mid && (i == 10);
      start = g_start_mid && (i == 5);
      @(negedge clk);
    end
    fire = 0; start = 0;
    det = 1;            // R2: pulse outside any frame, must not count
    @(negedge clk); det = 0;
    @(negedge clk);
  endtask

  // mode 0: single return at r; mode 1: r and r+1 alternate; mode 2: bins 0..31
  task automatic run_search(input int n, input int mode, input int r);
    int ne;
    ne = (n == 0) ? 1 : n;
    done_seen = 0;
    @(negedge clk); cfg = 8'(n); start = 1;
    @(negedge clk); start = 0;
    check_eq("R1 busy after start", int'(busy), 1);
    for (int f = 0; f < 8*ne; f++) begin
      if (mode == 0)      run_frame(r, r);
      else if (mode == 1) run_frame(r + (f % 2), r + (f % 2));
      else                run_frame(0, 31);
    end
    repeat (3) @(negedge clk);
    check_eq("R8 single done pulse", done_seen, 1);
    check_eq("R1 busy cleared", int'(busy), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    cmp_en = 1;
    // R9 reset state
    check_eq("R9 busy", int'(busy), 0);
    check_eq("R9 done", int'(done), 0);
    check_eq("R9 code", int'(code), 0);
    check_eq("R9 fine_bin", int'(fbin), 0);
    check_eq("R9 fine_a", int'(fa), 0);
    check_eq("R9 fine_b", int'(fb), 0);

    // R2: strobe while idle opens nothing, so a later search is unaffected
    @(negedge clk); fire = 1; det = 1;
    @(negedge clk); fire = 0;
    repeat (3) @(negedge clk); det = 0;

    // R3 R6: clean single return
    run_search(4, 0, 37);
    check_eq("R3 code 37", int'(code), 37);
    check_eq("R6 fine_a bin37", int'(fa), 4);
    check_eq("R6 fine_b bin38", int'(fb), 0);
    repeat (10) @(negedge clk);
    check_eq("R8 code holds", int'(code), 37);

    // R3 tie: zero count keeps the earlier half
    run_search(4, 1, 20);
    check_eq("R3 tie code 20", int'(code), 20);
    check_eq("R6 fine_a split", int'(fa), 2);
    check_eq("R6 fine_b split", int'(fb), 2);

    // R7 clamp at last bin, with ignored strobes (R2) and starts (R1)
    g_fire_mid = 1; g_start_mid = 1;
    run_search(3, 0, 63);
    g_fire_mid = 0; g_start_mid = 0;
    check_eq("R7 code 63", int'(code), 63);
    check_eq("R7 fine_bin clamp", int'(fbin), 62);
    check_eq("R7 fine_a bin62", int'(fa), 0);
    check_eq("R7 fine_b bin63", int'(fb), 3);

    // R4 saturation: 640 up-counts would wrap negative without clamping
    run_search(20, 2, 0);
    check_eq("R4 saturated code", int'(code), 0);
    check_eq("R4 fine_a bin0", int'(fa), 20);
    check_eq("R4 fine_b bin1", int'(fb), 20);

    // R5 zero frame setting acts as one frame
    run_search(0, 0, 10);
    check_eq("R5 code 10", int'(code), 10);
    check_eq("R5 fine_a single frame", int'(fa), 1);
    check_eq("R5 fine_b", int'(fb), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 190000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule